// File: doc/BRIEF.md
# Runtime-Programmable Galois Sequence Generator with Slow Step Divider

This block holds a small Galois-form linear-feedback shift register whose feedback mask and starting value are both written at run time from a shared 5-bit data input. Each of the two registers has its own load strobe. A free-running divider counts system clock cycles and lets the register take one step each time a full divider period has passed. At the default 625-cycle period on a 625 Hz clock, that is about one step per second.

The current value is driven out as a raw bus. It is also decoded into an active-high seven-segment pattern for a single display digit. Raising both strobes in the same cycle is not a load. It is a request to give the shared output pins to a different engine, and the block reports that request on a mode flag while it freezes its own registers.

Top module: `lfsr_ticker`

## Requirements
- R1: While rst_n is low, and until its release has passed through the two-stage synchroniser, the value register, the mask register and the divider count are all zero. The output reads 0 and the segment pattern reads 0x3F.
- R2: A clock edge with ld_taps_i high and ld_seed_i low copies din_i into the mask register and leaves state_o unchanged.
- R3: A clock edge with ld_seed_i high and ld_taps_i low copies din_i into the value register, so state_o equals that din_i right after the edge.
- R4: The divider count only moves on an edge where both strobes are low. An edge with exactly one strobe high keeps the count at its value.
- R5: On an edge where both strobes are low, a count below TICKS_PER_STEP-1 goes up by one and state_o holds. At TICKS_PER_STEP-1 the count returns to zero and state_o becomes (s >> 1) XOR (mask if s[0] is 1, else 0).
- R6: cpu_mode_o is 1 in exactly the cycles where both strobes are high. On such an edge neither register changes and the divider count is forced to zero.
- R7: seg_o[6:0] shows state_o[3:0] as a hex digit, active high, with bit 0 = segment a through bit 6 = segment g (0:3F 1:06 2:5B 3:4F 4:66 5:6D 6:7D 7:07 8:7F 9:6F A:77 b:7C C:39 d:5E E:79 F:71). seg_o[7] (the decimal point) equals state_o[4].
- R8: A value of zero stays at zero across steps for any mask. This is not flagged as an error.
- R9: With mask 0x12 and a nonzero seed, state_o first returns to the seed after exactly 31 steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ld_taps_i | input | 1 | Load strobe for the feedback mask |
| ld_seed_i | input | 1 | Load strobe for the current value |
| din_i | input | WIDTH | Shared load data |
| state_o | output | WIDTH | Current register value |
| seg_o | output | 8 | Seven-segment pattern, bit 7 is the decimal point |
| cpu_mode_o | output | 1 | High while both strobes are held together |

## Verification
The bench builds the block with WIDTH 5 and TICKS_PER_STEP 4, so a step lands every fourth idle cycle. At that period the full 31-state orbit of a maximal mask, strobes that arrive in the middle of a count, and a sweep of all 32 seed values through the segment decoder all fit in a few hundred cycles. At the default 625-cycle period, a single orbit alone would take about 19,000 cycles.

// File: rtl/lfsr_pkg.sv
package lfsr_pkg;

  typedef enum logic [1:0] {
    CMD_RUN  = 2'b00,
    CMD_TAPS = 2'b01,
    CMD_SEED = 2'b10,
    CMD_CPU  = 2'b11
  } load_cmd_e;

  // Strobes are decoded once; both together means hand-over, not load.
  function automatic load_cmd_e decode_cmd(input logic ld_taps, input logic ld_seed);
    load_cmd_e c;
    case ({ld_seed, ld_taps})
      2'b01:   c = CMD_TAPS;
      2'b10:   c = CMD_SEED;
      2'b11:   c = CMD_CPU;
      default: c = CMD_RUN;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/lfsr_rst_sync.sv
module lfsr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/lfsr_tick_div.sv
module lfsr_tick_div
  import lfsr_pkg::*;
#(
  parameter int unsigned TICKS_PER_STEP = 625
) (
  input  logic      clk,
  input  logic      rst_n,
  input  load_cmd_e cmd,
  output logic      step_o
);
  localparam int unsigned CW = (TICKS_PER_STEP > 1) ? $clog2(TICKS_PER_STEP) : 1;
  localparam logic [CW-1:0] TERM = CW'(TICKS_PER_STEP - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    step_o = 1'b0;
    case (cmd)
      CMD_CPU: begin
        cnt_en = 1'b1;
        cnt_d  = '0;
      end
      CMD_RUN: begin
        cnt_en = 1'b1;
        if (cnt_q == TERM) begin
          cnt_d  = '0;
          step_o = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  a_r4_hold_on_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_TAPS || cmd == CMD_SEED) |=> (cnt_q == $past(cnt_q)));

  a_r6_clear_on_handover: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_CPU) |=> (cnt_q == '0));

  a_r5_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= TERM);

  a_r5_step_only_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    step_o |-> (cmd == CMD_RUN));
endmodule

// File: rtl/lfsr_core.sv
module lfsr_core
  import lfsr_pkg::*;
#(
  parameter int unsigned WIDTH = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  load_cmd_e        cmd,
  input  logic [WIDTH-1:0] din,
  input  logic             step_i,
  output logic [WIDTH-1:0] state_o
);
  logic [WIDTH-1:0] state_q, state_d, taps_q, taps_d, shifted;
  logic             state_en, taps_en;

  assign shifted = (state_q >> 1) ^ ({WIDTH{state_q[0]}} & taps_q);

  always_comb begin
    taps_en  = (cmd == CMD_TAPS);
    taps_d   = din;
    state_en = 1'b0;
    state_d  = state_q;
    if (cmd == CMD_SEED) begin
      state_en = 1'b1;
      state_d  = din;
    end else if (cmd == CMD_RUN && step_i) begin
      state_en = 1'b1;
      state_d  = shifted;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       taps_q <= '0;
    else if (taps_en) taps_q <= taps_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        state_q <= '0;
    else if (state_en) state_q <= state_d;
  end

  assign state_o = state_q;

  a_r6_regs_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_CPU) |=> (state_q == $past(state_q) && taps_q == $past(taps_q)));

  a_r3_seed_loaded: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_SEED) |=> (state_q == $past(din)));

  a_r2_taps_keep_state: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_TAPS) |=> (state_q == $past(state_q) && taps_q == $past(din)));

  a_r8_zero_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == '0 && cmd != CMD_SEED) |=> (state_q == '0));
endmodule

// File: rtl/lfsr_seg7.sv
module lfsr_seg7 #(
  parameter int unsigned WIDTH = 5
) (
  input  logic [WIDTH-1:0] value,
  output logic [7:0]       seg
);
  logic [6:0] glyph;

  always_comb begin
    case (value[3:0])
      4'h0: glyph = 7'h3F;
      4'h1: glyph = 7'h06;
      4'h2: glyph = 7'h5B;
      4'h3: glyph = 7'h4F;
      4'h4: glyph = 7'h66;
      4'h5: glyph = 7'h6D;
      4'h6: glyph = 7'h7D;
      4'h7: glyph = 7'h07;
      4'h8: glyph = 7'h7F;
      4'h9: glyph = 7'h6F;
      4'hA: glyph = 7'h77;
      4'hB: glyph = 7'h7C;
      4'hC: glyph = 7'h39;
      4'hD: glyph = 7'h5E;
      4'hE: glyph = 7'h79;
      default: glyph = 7'h71;
    endcase
  end

  assign seg = {|value[WIDTH-1:4], glyph};

  // R7: every hex digit lights at least two segments
  always_comb begin
    a_r7_never_dim: assert ($countones(glyph) >= 2);
  end
endmodule

// File: rtl/lfsr_ticker.sv
module lfsr_ticker
  import lfsr_pkg::*;
#(
  parameter int unsigned WIDTH          = 5,
  parameter int unsigned TICKS_PER_STEP = 625
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_taps_i,
  input  logic             ld_seed_i,
  input  logic [WIDTH-1:0] din_i,
  output logic [WIDTH-1:0] state_o,
  output logic [7:0]       seg_o,
  output logic             cpu_mode_o
);
  logic      rst_sync_n;
  logic      step;
  load_cmd_e cmd;

  assign cmd        = decode_cmd(ld_taps_i, ld_seed_i);
  assign cpu_mode_o = (cmd == CMD_CPU);

  lfsr_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  lfsr_tick_div #(.TICKS_PER_STEP(TICKS_PER_STEP)) u_div (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .cmd    (cmd),
    .step_o (step)
  );

  lfsr_core #(.WIDTH(WIDTH)) u_core (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .cmd     (cmd),
    .din     (din_i),
    .step_i  (step),
    .state_o (state_o)
  );

  lfsr_seg7 #(.WIDTH(WIDTH)) u_seg (
    .value (state_o),
    .seg   (seg_o)
  );
endmodule

// File: tb/tb_lfsr_ticker.sv
module tb_lfsr_ticker;
  localparam int W = 5;
  localparam int T = 4;

  typedef struct {
    logic [W-1:0] st;
    logic [7:0]   sg;
    logic         md;
    string        tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ld_taps = 1'b0, ld_seed = 1'b0;
  logic [W-1:0] din = '0;
  logic [W-1:0] state_o;
  logic [7:0]   seg_o;
  logic         cpu_mode_o;

  int compared = 0, mismatched = 0;
  exp_t q[$];

  logic [W-1:0] m_state = '0, m_taps = '0;
  int           m_cnt = 0;

  always #5 clk = ~clk;

  lfsr_ticker #(.WIDTH(W), .TICKS_PER_STEP(T)) dut (
    .clk(clk), .rst_n(rst_n), .ld_taps_i(ld_taps), .ld_seed_i(ld_seed),
    .din_i(din), .state_o(state_o), .seg_o(seg_o), .cpu_mode_o(cpu_mode_o)
  );

  function automatic logic [7:0] seg_of(input logic [W-1:0] v);
    logic [6:0] g;
    case (v[3:0])
      4'h0: g = 7'h3F; 4'h1: g = 7'h06; 4'h2: g = 7'h5B; 4'h3: g = 7'h4F;
      4'h4: g = 7'h66; 4'h5: g = 7'h6D; 4'h6: g = 7'h7D; 4'h7: g = 7'h07;
      4'h8: g = 7'h7F; 4'h9: g = 7'h6F; 4'hA: g = 7'h77; 4'hB: g = 7'h7C;
      4'hC: g = 7'h39; 4'hD: g = 7'h5E; 4'hE: g = 7'h79; default: g = 7'h71;
    endcase
    return {v[4], g};
  endfunction

  task automatic check(input string tag, input logic ok, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Driver: apply one cycle of stimulus, advance the model, queue the expectation.
  task automatic cyc(input logic lt, input logic ls, input logic [W-1:0] d, input string tag);
    exp_t e;
    @(negedge clk); #1;
    ld_taps = lt; ld_seed = ls; din = d;
    @(posedge clk);
    if (lt && ls) m_cnt = 0;                       // R6
    else if (lt) m_taps = d;                       // R2
    else if (ls) m_state = d;                      // R3
    else if (m_cnt == T - 1) begin                 // R5
      m_cnt = 0;
      m_state = (m_state >> 1) ^ ({W{m_state[0]}} & m_taps);
    end else m_cnt++;                              // R4
    #1;
    e.st = m_state; e.sg = seg_of(m_state); e.md = lt && ls; e.tag = tag;
    q.push_back(e);
  endtask

  // Monitor: compare the oldest expectation while the inputs are still steady.
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check({e.tag, " state"}, state_o === e.st, int'(state_o), int'(e.st));
      check({e.tag, " seg R7"}, seg_o === e.sg, int'(seg_o), int'(e.sg));
      check({e.tag, " mode R6"}, cpu_mode_o === e.md, int'(cpu_mode_o), int'(e.md));
    end
  end

  initial begin
    #2_000_000;
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    int first;
    // R1: reset state
    repeat (3) @(posedge clk);
    #1;
    check("R1 state", state_o === '0, int'(state_o), 0);
    check("R1 seg", seg_o === 8'h3F, int'(seg_o), 'h3F);
    @(negedge clk); #1;
    ld_taps = 1'b1; ld_seed = 1'b1;
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check("R6 mode out", cpu_mode_o === 1'b1, int'(cpu_mode_o), 1);
    check("R1 state after release", state_o === '0, int'(state_o), 0);

    cyc(1, 1, 5'h1F, "R6");
    cyc(1, 0, 5'h12, "R2");
    cyc(0, 1, 5'h01, "R3");
    for (int i = 0; i < 40; i++) cyc(0, 0, 5'h0A, "R5");

    // mid-count strobes
    cyc(0, 0, 0, "R5");
    cyc(0, 0, 0, "R5");
    cyc(0, 1, 5'h1F, "R4");
    for (int i = 0; i < 6; i++) cyc(0, 0, 0, "R4");
    cyc(1, 0, 5'h17, "R2");
    for (int i = 0; i < 9; i++) cyc(0, 0, 0, "R5");
    cyc(1, 1, 5'h03, "R6");
    for (int i = 0; i < 9; i++) cyc(0, 0, 0, "R5");

    // R8: zero state sticks
    cyc(0, 1, 5'h00, "R3");
    for (int i = 0; i < 12; i++) cyc(0, 0, 5'h1F, "R8");

    // R7: sweep every seed value through the decoder
    for (int v = 0; v < 32; v++) cyc(0, 1, W'(v), "R7");

    // R9: orbit length with a maximal mask
    cyc(1, 1, 0, "R6");
    cyc(1, 0, 5'h12, "R9");
    cyc(0, 1, 5'h01, "R9");
    first = 0;
    for (int k = 1; k <= 40; k++) begin
      for (int c = 0; c < T; c++) cyc(0, 0, 0, "R9");
      if (first == 0 && state_o === 5'h01) first = k;
    end
    check("R9 period", first == 31, first, 31);

    repeat (3) @(posedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule